// File: doc/BRIEF.md
# Wavefront Memory Issue Hazard Gate

This block sits in front of the issue stage for one wavefront. Each cycle it looks at the oldest instruction of that wavefront and decides whether the instruction may issue in that same cycle. When the answer is yes, it reserves the shared resources the instruction will occupy. These resources are an ALU issue slot and ALU pipe, and, for each of the two memory spaces (global and local), a register-to-memory data bus, a memory-unit issue slot and a share of that unit's request FIFO. Decode, operand scoreboarding and the memory access itself happen elsewhere. Operand readiness arrives as a single bit.

For each memory space the gate keeps a count of reads and a count of writes that have issued but not yet completed. Ordering is enforced by direction. A read-type access waits until the writes of its space have drained. A write-type access waits until the reads of its space have drained. An atomic or a fence waits until both have drained. Completion pulses from the memory side decrement the counts. A flat access is presented with the space it resolved to. A flat access that has not resolved, or an instruction class that is not known, is never allowed to issue and is flagged as illegal.

Top module: `wfgate`

## Requirements
- R1: After reset, all in-flight counts are zero and all busy timers are idle, so a load to global space (class 5, space 1) with operands ready is accepted in the first cycle after reset is released. With `inst_valid` low, neither `issue_ok` nor `illegal_op` is set.
- R2: A load (class 5) is not issued while its own space has any write in flight.
- R3: A store (class 6) is not issued while its own space has any read in flight.
- R4: An atomic (class 7) or fence (class 8) waits until both the read count and the write count of its space are zero. Once it issues, it adds one to both counts.
- R5: Global (space code 1, completion bit 0) and local (space code 2, completion bit 1) each have their own counts, bus timer, issue-slot timer and FIFO budget. Traffic in one space never blocks the other.
- R6: An issued load holds its space's data bus busy for the 4 cycles that follow the issue. An issued store, atomic or fence holds it busy for the 8 cycles that follow. No memory instruction to that space issues while its bus is busy.
- R7: Every issued instruction, except a nop, holds the issue slot of its unit (ALU unit, global unit or local unit) busy for the ISSUE_PERIOD cycles that follow the issue. An instruction of the ALU unit, nop included, needs that slot free before it issues.
- R8: ALU (0), branch (1) and return (2) also hold the ALU pipe busy for the BYPASS_LEN cycles that follow, and each needs the pipe free before it issues. A barrier (4) reserves only the slot. A nop (3) reserves nothing.
- R9: A memory instruction issues only when the sum of its space's read and write counts is below FIFO_DEPTH.
- R10: A completion pulse decrements the matching count. An issue and a completion to the same count in the same cycle leave that count unchanged. A pulse against a zero count leaves it at zero.
- R11: A class code from 9 to 15, or a memory class whose space code is 0 (unresolved) or 3, gives `illegal_op` high and `issue_ok` low while `inst_valid` is high.
- R12: With `inst_valid` or `operands_ready` low, `issue_ok` stays low and nothing is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Oldest instruction slot holds an instruction |
| inst_class | input | 4 | Class: 0 ALU, 1 branch, 2 return, 3 nop, 4 barrier, 5 load, 6 store, 7 atomic, 8 fence |
| inst_space | input | 2 | Memory space: 0 unresolved, 1 global, 2 local, 3 invalid |
| operands_ready | input | 1 | Source and destination operands are available |
| rd_done | input | 2 | Read completion pulse per space (bit 0 global, bit 1 local) |
| wr_done | input | 2 | Write completion pulse per space (bit 0 global, bit 1 local) |
| issue_ok | output | 1 | Instruction issues this cycle and its resources are reserved at the edge |
| illegal_op | output | 1 | Instruction class or resolved space is not legal |

## Verification
The hardest cases to reach from the ports are a full request FIFO and a count that sees an issue and a completion in the same cycle. Getting there needs several loads to one space, each spaced past the 4-cycle bus hold, with no completion arriving in between. The completion pulse must then land in exactly the cycle where the next load goes out. Directed sequences build these states cycle by cycle, and also drive completion pulses against empty counts. A long random run then mixes classes, spaces and pulses against a cycle-level model kept in the bench.

// File: rtl/wfgate_pkg.sv
package wfgate_pkg;

    localparam int NUM_SPACES  = 2;
    localparam int RD_BUS_CYC  = 4;
    localparam int WR_BUS_CYC  = 8;

    typedef enum logic [3:0] {
        CL_ALU     = 4'd0,
        CL_BRANCH  = 4'd1,
        CL_RETURN  = 4'd2,
        CL_NOP     = 4'd3,
        CL_BARRIER = 4'd4,
        CL_LOAD    = 4'd5,
        CL_STORE   = 4'd6,
        CL_ATOMIC  = 4'd7,
        CL_FENCE   = 4'd8
    } op_class_e;

    typedef enum logic [1:0] {
        SP_NONE   = 2'd0,
        SP_GLOBAL = 2'd1,
        SP_LOCAL  = 2'd2,
        SP_BAD    = 2'd3
    } mem_space_e;

    typedef struct packed {
        logic known;      // class code is recognised
        logic mem;        // goes to a memory unit
        logic rd_side;    // counts as a read, waits for writes
        logic wr_side;    // counts as a write, waits for reads
        logic alu_pipe;   // occupies the ALU pipe
        logic takes_slot; // occupies the ALU-unit issue slot
    } op_attr_t;

    function automatic op_attr_t decode_op(input logic [3:0] code);
        op_attr_t a;
        a = '0;
        case (op_class_e'(code))
            CL_ALU, CL_BRANCH, CL_RETURN: begin
                a.known = 1'b1; a.alu_pipe = 1'b1; a.takes_slot = 1'b1;
            end
            CL_NOP:     a.known = 1'b1;
            CL_BARRIER: begin a.known = 1'b1; a.takes_slot = 1'b1; end
            CL_LOAD:    begin a.known = 1'b1; a.mem = 1'b1; a.rd_side = 1'b1; end
            CL_STORE:   begin a.known = 1'b1; a.mem = 1'b1; a.wr_side = 1'b1; end
            CL_ATOMIC, CL_FENCE: begin
                a.known = 1'b1; a.mem = 1'b1; a.rd_side = 1'b1; a.wr_side = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wfgate_timer.sv
module wfgate_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         busy
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= len;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/wfgate_space_ctr.sv
module wfgate_space_ctr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_rd,
    input  logic          inc_wr,
    input  logic          dec_rd,
    input  logic          dec_wr,
    output logic [CW-1:0] rd_cnt,
    output logic [CW-1:0] wr_cnt
);
    function automatic logic [CW-1:0] step(input logic [CW-1:0] cur,
                                           input logic up, input logic down);
        if (up && !down)
            return cur + 1'b1;
        else if (down && !up && cur != '0)
            return cur - 1'b1;
        return cur;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else begin
            rd_cnt <= step(rd_cnt, inc_rd, dec_rd);
            wr_cnt <= step(wr_cnt, inc_wr, dec_wr);
        end
    end
endmodule

// File: rtl/wfgate.sv
module wfgate
    import wfgate_pkg::*;
#(
    parameter int ISSUE_PERIOD = 2,
    parameter int BYPASS_LEN   = 3,
    parameter int FIFO_DEPTH   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inst_valid,
    input  logic [3:0]            inst_class,
    input  logic [1:0]            inst_space,
    input  logic                  operands_ready,
    input  logic [NUM_SPACES-1:0] rd_done,
    input  logic [NUM_SPACES-1:0] wr_done,
    output logic                  issue_ok,
    output logic                  illegal_op
);
    localparam int NSP     = NUM_SPACES;
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam int LONG1   = (WR_BUS_CYC > ISSUE_PERIOD) ? WR_BUS_CYC : ISSUE_PERIOD;
    localparam int LONGEST = (LONG1 > BYPASS_LEN) ? LONG1 : BYPASS_LEN;
    localparam int TMR_W   = $clog2(LONGEST + 1);

    op_attr_t             attr;
    logic                 space_ok;
    logic                 space_idx;
    logic [NSP-1:0]       sel;
    logic [NSP-1:0]       mem_ready;
    logic [NSP-1:0]       mem_go;
    logic [NSP-1:0]       bus_busy;
    logic [NSP-1:0]       mslot_busy;
    logic [NSP-1:0][CNT_W-1:0] rd_cnt;
    logic [NSP-1:0][CNT_W-1:0] wr_cnt;
    logic                 aslot_busy;
    logic                 apipe_busy;
    logic                 alu_ready;
    logic                 unit_ready;
    logic                 alu_go;

    assign attr      = decode_op(inst_class);
    assign space_ok  = (inst_space == SP_GLOBAL) || (inst_space == SP_LOCAL);
    assign space_idx = (inst_space == SP_LOCAL);

    assign illegal_op = inst_valid && (!attr.known || (attr.mem && !space_ok));

    for (genvar s = 0; s < NSP; s++) begin : g_space
        logic [CNT_W:0] in_pipe;

        assign sel[s]   = attr.mem && space_ok && (int'(space_idx) == s);
        assign in_pipe  = {1'b0, rd_cnt[s]} + {1'b0, wr_cnt[s]};
        assign mem_ready[s] = !(attr.rd_side && wr_cnt[s] != '0)
                           && !(attr.wr_side && rd_cnt[s] != '0)
                           && !bus_busy[s]
                           && !mslot_busy[s]
                           && (int'(in_pipe) < FIFO_DEPTH);
        assign mem_go[s] = issue_ok && sel[s];

        wfgate_space_ctr #(.CW(CNT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .inc_rd (mem_go[s] && attr.rd_side),
            .inc_wr (mem_go[s] && attr.wr_side),
            .dec_rd (rd_done[s]),
            .dec_wr (wr_done[s]),
            .rd_cnt (rd_cnt[s]),
            .wr_cnt (wr_cnt[s])
        );

        wfgate_timer #(.W(TMR_W)) u_bus (
            .clk   (clk),
            .rst   (rst),
            .start (mem_go[s]),
            .len   (attr.wr_side ? TMR_W'(WR_BUS_CYC) : TMR_W'(RD_BUS_CYC)),
            .busy  (bus_busy[s])
        );

        wfgate_timer #(.W(TMR_W)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .start (mem_go[s]),
            .len   (TMR_W'(ISSUE_PERIOD)),
            .busy  (mslot_busy[s])
        );
    end

    assign alu_ready  = !aslot_busy && !(attr.alu_pipe && apipe_busy);
    assign unit_ready = attr.mem ? |(sel & mem_ready) : (attr.known && alu_ready);
    assign issue_ok   = inst_valid && operands_ready && !illegal_op && unit_ready;
    assign alu_go     = issue_ok && !attr.mem;

    wfgate_timer #(.W(TMR_W)) u_alu_slot (
        .clk   (clk),
        .rst   (rst),
        .start (alu_go && attr.takes_slot),
        .len   (TMR_W'(ISSUE_PERIOD)),
        .busy  (aslot_busy)
    );

    wfgate_timer #(.W(TMR_W)) u_alu_pipe (
        .clk   (clk),
        .rst   (rst),
        .start (alu_go && attr.alu_pipe),
        .len   (TMR_W'(BYPASS_LEN)),
        .busy  (apipe_busy)
    );
endmodule

// File: rtl/wfgate_chk.sv
module wfgate_chk
    import wfgate_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         inst_valid,
    input logic [3:0]                   inst_class,
    input logic                         operands_ready,
    input logic                         issue_ok,
    input logic                         illegal_op,
    input logic [NUM_SPACES-1:0]        rd_done,
    input logic [NUM_SPACES-1:0]        mem_go,
    input logic [NUM_SPACES-1:0][CW-1:0] rd_cnt,
    input logic [NUM_SPACES-1:0][CW-1:0] wr_cnt
);
    assert_needs_operands_R12: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> (inst_valid && operands_ready));

    assert_illegal_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !issue_ok);

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_chk
        assert_load_after_writes_R2: assert property (@(posedge clk) disable iff (rst)
            (mem_go[s] && inst_class == CL_LOAD) |-> (wr_cnt[s] == '0));

        assert_store_after_reads_R3: assert property (@(posedge clk) disable iff (rst)
            (mem_go[s] && inst_class == CL_STORE) |-> (rd_cnt[s] == '0));

        assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
            (int'(rd_cnt[s]) + int'(wr_cnt[s])) <= FIFO_DEPTH);

        assert_bus_hold_R6: assert property (@(posedge clk) disable iff (rst)
            mem_go[s] |=> !mem_go[s]);

        assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
            (rd_cnt[s] == '0 && rd_done[s] && !mem_go[s]) |=> (rd_cnt[s] == '0));
    end
endmodule

bind wfgate wfgate_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .inst_valid     (inst_valid),
    .inst_class     (inst_class),
    .operands_ready (operands_ready),
    .issue_ok       (issue_ok),
    .illegal_op     (illegal_op),
    .rd_done        (rd_done),
    .mem_go         (mem_go),
    .rd_cnt         (rd_cnt),
    .wr_cnt         (wr_cnt)
);

// File: tb/wfgate_tb.sv
module wfgate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IP = 2;
    localparam int BP = 3;
    localparam int FD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inst_valid = 1'b0;
    logic [3:0] inst_class = '0;
    logic [1:0] inst_space = '0;
    logic       operands_ready = 1'b0;
    logic [1:0] rd_done = '0;
    logic [1:0] wr_done = '0;
    logic       issue_ok;
    logic       illegal_op;

    int checks = 0;
    int fails  = 0;

    // model state
    int m_rd [2];
    int m_wr [2];
    int m_bus [2];
    int m_mslot [2];
    int m_aslot;
    int m_apipe;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfgate #(.ISSUE_PERIOD(IP), .BYPASS_LEN(BP), .FIFO_DEPTH(FD)) u_dut (
        .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_class(inst_class),
        .inst_space(inst_space), .operands_ready(operands_ready),
        .rd_done(rd_done), .wr_done(wr_done),
        .issue_ok(issue_ok), .illegal_op(illegal_op)
    );

    function automatic bit is_mem(int c);
        return c >= 5 && c <= 8;
    endfunction
    function automatic bit rd_side(int c);
        return c == 5 || c == 7 || c == 8;
    endfunction
    function automatic bit wr_side(int c);
        return c == 6 || c == 7 || c == 8;
    endfunction

    function automatic bit exp_ill();
        int c = int'(inst_class);
        if (!inst_valid) return 1'b0;
        if (c > 8) return 1'b1;
        if (is_mem(c) && !(inst_space == 2'd1 || inst_space == 2'd2)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_ok();
        int c = int'(inst_class);
        int s;
        if (!inst_valid || !operands_ready || exp_ill()) return 1'b0;
        if (is_mem(c)) begin
            s = (inst_space == 2'd2) ? 1 : 0;
            if (rd_side(c) && m_wr[s] > 0) return 1'b0;
            if (wr_side(c) && m_rd[s] > 0) return 1'b0;
            if (m_bus[s] > 0 || m_mslot[s] > 0) return 1'b0;
            if (m_rd[s] + m_wr[s] >= FD) return 1'b0;
            return 1'b1;
        end
        if (m_aslot > 0) return 1'b0;
        if (c <= 2 && m_apipe > 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_rd[s] = 0; m_wr[s] = 0; m_bus[s] = 0; m_mslot[s] = 0;
        end
        m_aslot = 0; m_apipe = 0;
    endtask

    task automatic drive(input bit v, input int c, input int sp, input bit ops,
                         input logic [1:0] rdd, input logic [1:0] wrd);
        @(negedge clk);
        inst_valid = v; inst_class = 4'(c); inst_space = 2'(sp);
        operands_ready = ops; rd_done = rdd; wr_done = wrd;
        #1;
    endtask

    // compare against the model, then commit the edge
    task automatic tick();
        bit ok;
        int c;
        int s;
        ok = exp_ok();
        check("model issue_ok", issue_ok, ok);
        check("model illegal_op", illegal_op, exp_ill());
        c = int'(inst_class);
        s = (inst_space == 2'd2) ? 1 : 0;
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (m_bus[k] > 0) m_bus[k]--;
            if (m_mslot[k] > 0) m_mslot[k]--;
        end
        if (m_aslot > 0) m_aslot--;
        if (m_apipe > 0) m_apipe--;
        for (int k = 0; k < 2; k++) begin
            bit ir = ok && is_mem(c) && s == k && rd_side(c);
            bit iw = ok && is_mem(c) && s == k && wr_side(c);
            if (ir && !rd_done[k]) m_rd[k]++;
            else if (!ir && rd_done[k] && m_rd[k] > 0) m_rd[k]--;
            if (iw && !wr_done[k]) m_wr[k]++;
            else if (!iw && wr_done[k] && m_wr[k] > 0) m_wr[k]--;
        end
        if (ok) begin
            if (is_mem(c)) begin
                m_bus[s] = wr_side(c) ? 8 : 4;
                m_mslot[s] = IP;
            end else begin
                if (c != 3) m_aslot = IP;
                if (c <= 2) m_apipe = BP;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 0, 2'b00, 2'b00);
            tick();
        end
    endtask

    task automatic try(input string tag, input int c, input int sp, input bit ops,
                       input logic [1:0] rdd, input logic [1:0] wrd,
                       input logic eok, input logic eill);
        drive(1, c, sp, ops, rdd, wrd);
        check({tag, " issue_ok"}, issue_ok, eok);
        check({tag, " illegal_op"}, illegal_op, eill);
        tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; inst_valid = 0; rd_done = 0; wr_done = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        do_reset();

        // R1: reset state
        drive(0, 9, 0, 1, 2'b00, 2'b00);
        check("R1 idle issue_ok", issue_ok, 1'b0);
        check("R1 idle illegal_op", illegal_op, 1'b0);
        tick();
        try("R1 first load", 5, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);

        // R3 / R5 / R2
        try("R3 store behind read", 6, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R5 local store free", 6, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R2 load behind write", 5, 2, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R8 nop free", 3, 0, 1, 2'b00, 2'b10, 1'b1, 1'b0);

        // R6: bus timing
        do_reset();
        try("R6 load c0", 5, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R6 load c1", 5, 1, 1, 2'b01, 2'b00, 1'b0, 1'b0);
        for (int i = 2; i <= 4; i++) try("R6 load busy", 5, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R6 load after 4", 5, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R3 store pending read", 6, 1, 1, 2'b01, 2'b00, 1'b0, 1'b0);
        for (int i = 7; i <= 9; i++) try("R6 store bus busy", 6, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R6 store c10", 6, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        for (int i = 11; i <= 18; i++) try("R6 store 8 busy", 6, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R6 store c19", 6, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);

        // R7 / R8: ALU unit
        do_reset();
        try("R8 alu c0", 0, 0, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R7 barrier slot", 4, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R7 barrier slot", 4, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R7 barrier free", 4, 0, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R7 alu slot", 0, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R7 alu slot", 0, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R8 alu c6", 1, 0, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        try("R7 nop slot", 3, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R7 branch slot", 1, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R8 return pipe", 2, 0, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R8 return free", 2, 0, 1, 2'b00, 2'b00, 1'b1, 1'b0);

        // R9 / R10: FIFO budget and same-cycle update
        do_reset();
        for (int k = 0; k < 4; k++) begin
            try("R9 fill", 5, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);
            idle(4);
        end
        try("R9 fifo full", 5, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R9 full with done", 5, 1, 1, 2'b01, 2'b00, 1'b0, 1'b0);
        try("R10 issue plus done", 5, 1, 1, 2'b01, 2'b00, 1'b1, 1'b0);
        try("R5 local own fifo", 5, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        idle(3);
        try("R10 count held", 5, 1, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        idle(4);
        try("R9 full again", 5, 1, 1, 2'b00, 2'b00, 1'b0, 1'b0);

        // R10: no underflow
        do_reset();
        drive(0, 0, 0, 0, 2'b11, 2'b11); tick();
        try("R10 load after empty pulse", 5, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        idle(4);
        try("R10 wr pulse on zero", 6, 1, 1, 2'b00, 2'b01, 1'b1, 1'b0);

        // R4: atomic / fence
        do_reset();
        try("R4 load L", 5, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        idle(4);
        try("R4 fence behind read", 8, 2, 1, 2'b10, 2'b00, 1'b0, 1'b0);
        try("R4 fence free", 8, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);
        idle(8);
        try("R4 store behind fence", 6, 2, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R4 load behind fence", 5, 2, 1, 2'b00, 2'b00, 1'b0, 1'b0);
        try("R4 atomic behind fence", 7, 2, 1, 2'b10, 2'b10, 1'b0, 1'b0);
        try("R4 atomic free", 7, 2, 1, 2'b00, 2'b00, 1'b1, 1'b0);

        // R11 / R12
        try("R11 unknown class", 9, 1, 1, 2'b00, 2'b00, 1'b0, 1'b1);
        try("R11 unresolved flat", 5, 0, 1, 2'b00, 2'b00, 1'b0, 1'b1);
        try("R11 bad space", 6, 3, 1, 2'b00, 2'b00, 1'b0, 1'b1);
        try("R12 operands low", 5, 1, 0, 2'b00, 2'b00, 1'b0, 1'b0);
        drive(0, 15, 0, 1, 2'b00, 2'b00);
        check("R12 invalid no flag", illegal_op, 1'b0);
        tick();

        // random phase against the model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            int c = (r < 5) ? $urandom_range(9, 15) : $urandom_range(0, 8);
            int sp = ($urandom_range(0, 19) == 0) ? $urandom_range(0, 3) : $urandom_range(1, 2);
            drive($urandom_range(0, 9) != 0, c, sp, $urandom_range(0, 9) != 0,
                  2'($urandom_range(0, 3) & $urandom_range(0, 3)),
                  2'($urandom_range(0, 3) & $urandom_range(0, 3)));
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule